// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is the slave side of a two-channel serial audio link. It watches three wires driven by an external source: a bit clock, a frame clock whose level tells the two channels apart, and a serial data line. A three-bit format select chooses one of five framings: three right-justified word lengths, a left-justified 24-bit framing, and I2S. For every frame the block rebuilds the left and right samples and presents them together as two's-complement words, with a one-cycle strobe that marks a new stereo pair.

The three link wires are sampled with a faster system clock. A parameterized synchronizer chain guards against metastability, and a rising bit-clock edge is detected in the system clock domain. With a synchronizer depth of zero the wires are used as they arrive, which suits a source already timed to the system clock. Every bit is taken on a rising bit-clock edge, MSB first. Each change of frame-clock level seen at such an edge ends one half-frame and starts the next. Shorter words are placed at the top of the output word, so the sign bit stays at the top and the value keeps its scale.

Top module: `ser_audio_rx`

## Requirements
- R1: While rst_n is low, and after release until the first stereo pair is complete, valid_o is 0 and left_o and right_o are all zeros.
- R2: With fmt_sel_i = 2, the bit taken at the first bit-clock rise after a frame-clock transition is the MSB, and the following 23 bits complete the 24-bit word. Any later bits in the half are ignored. 24 bit clocks per half (48 per frame) are enough.
- R3: With fmt_sel_i = 3 (I2S), the MSB is the bit at the second bit-clock rise after the transition, and a low frame clock marks the left half. With 24 bit clocks per half, the LSB arrives at the first rise of the next half and still belongs to the word that just ended.
- R4: With fmt_sel_i = 4, the word is the last 24 bits before the next frame-clock transition, and the bits before them are ignored.
- R5: With fmt_sel_i = 0, the last 16 bits of the half go to output bits 23:8 and bits 7:0 are zero. The earlier bits are ignored, and 16 bit clocks per half are enough.
- R6: With fmt_sel_i = 1, the last 20 bits of the half go to output bits 23:4 and bits 3:0 are zero. The earlier bits are ignored, and 20 bit clocks per half are enough.
- R7: Format codes 5, 6 and 7 behave exactly like code 2.
- R8: A stereo pair is complete when a right half ends and a left half was captured before it. valid_o then pulses high for one clock, sampled SYNC_STAGES+1 rising clk edges after the bit-clock rise that shows the transition. A right half with no left half before it produces no pulse.
- R9: For codes other than 3, a high frame clock marks the left half. left_o and right_o change only in the cycle where valid_o is high and hold their values otherwise.
- R10: A half-frame counts only if a frame-clock transition seen after reset started it. Bits that arrive before the first transition produce no output.
- R11: The framing is taken from fmt_sel_i when each half-frame starts, so a change made between frames applies from the next half onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the source |
| lrck_i | input | 1 | Frame clock; its level selects the channel |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_sel_i | input | 3 | Framing select (0..4; 5..7 act as 2) |
| left_o | output | SAMPLE_W | Left sample of the latest pair |
| right_o | output | SAMPLE_W | Right sample of the latest pair |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
Random left and right words are sent in every framing. Each framing uses a half length equal to its minimum and also a longer half that is filled with ones, so a wrong window position or a filler bit that leaks in produces a wrong value. The bench switches formats back to back, including across frame-clock polarities with a separating half, and leads off with unbounded bits before the first transition. This separates the handling of latched formats, the arming after reset, and the pairing of left with right. The valid pulse is compared against a bit-event timing model on every clock, so a wrong synchronizer latency, a lost I2S LSB or a spurious pair all show up.

// File: rtl/ser_audio_rx_pkg.sv
package ser_audio_rx_pkg;

   typedef enum logic [2:0] {
      FMT_RJ16 = 3'd0,
      FMT_RJ20 = 3'd1,
      FMT_LJ24 = 3'd2,
      FMT_I2S  = 3'd3,
      FMT_RJ24 = 3'd4
   } fmt_e;

   // Unused codes fall back to the left-justified framing.
   function automatic fmt_e fmt_decode(input logic [2:0] code);
      fmt_e f;
      case (code)
         3'd0:    f = FMT_RJ16;
         3'd1:    f = FMT_RJ20;
         3'd3:    f = FMT_I2S;
         3'd4:    f = FMT_RJ24;
         default: f = FMT_LJ24;
      endcase
      return f;
   endfunction

   // I2S marks the left channel with a low frame clock.
   function automatic logic fmt_left_is_low(input fmt_e f);
      return (f == FMT_I2S);
   endfunction

endpackage

// File: rtl/ser_audio_rx_sync.sv
module ser_audio_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrck_i,
   input  logic sdata_i,
   output logic bit_stb,
   output logic lr_bit,
   output logic dat_bit
);

   localparam int LANES = 3;

   generate
      if (STAGES < 0 || STAGES > 6) begin : g_bad_depth
         $error("ser_audio_rx_sync: STAGES must lie in 0..6");
      end
   endgenerate

   logic [LANES-1:0] raw;
   logic [LANES-1:0] synced;
   logic             bclk_q;

   assign raw = {bclk_i, lrck_i, sdata_i};

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [LANES-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign synced = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= synced[2];
   end

   assign bit_stb = synced[2] & ~bclk_q;
   assign lr_bit  = synced[1];
   assign dat_bit = synced[0];

endmodule

// File: rtl/ser_audio_rx_deser.sv
module ser_audio_rx_deser
   import ser_audio_rx_pkg::*;
#(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_stb,
   input  logic         lr_bit,
   input  logic         dat_bit,
   input  logic [2:0]   fmt_code,
   output logic         half_done,
   output logic         half_left,
   output logic [W-1:0] half_word
);

   localparam int CW = $clog2(W + 1);

   generate
      if (W < 24) begin : g_bad_w
         $error("ser_audio_rx_deser: W must be at least 24");
      end
   endgenerate

   fmt_e          fmt_q;
   fmt_e          fmt_new;
   logic          lr_prev;
   logic          armed;
   logic          lr_edge;
   logic [W-1:0]  rj_sh;
   logic [W-1:0]  lj_sh;
   logic [CW-1:0] lj_cnt;

   assign fmt_new   = fmt_decode(fmt_code);
   assign lr_edge   = bit_stb & (lr_bit != lr_prev);
   assign half_done = lr_edge & armed;
   assign half_left = lr_prev ^ fmt_left_is_low(fmt_q);

   // Word assembly for the half that ends at this strobe.
   always_comb begin
      case (fmt_q)
         FMT_RJ16: half_word = rj_sh << (W - 16);
         FMT_RJ20: half_word = rj_sh << (W - 20);
         FMT_RJ24: half_word = rj_sh << (W - 24);
         FMT_I2S:  half_word = (lj_cnt == CW'(W - 1)) ? {lj_sh[W-2:0], dat_bit} : lj_sh;
         default:  half_word = lj_sh;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q   <= FMT_LJ24;
         lr_prev <= 1'b0;
         armed   <= 1'b0;
         rj_sh   <= '0;
         lj_sh   <= '0;
         lj_cnt  <= '0;
      end else if (bit_stb) begin
         lr_prev <= lr_bit;
         rj_sh   <= {rj_sh[W-2:0], dat_bit};
         if (lr_edge) begin
            armed <= 1'b1;
            fmt_q <= fmt_new;
            if (fmt_left_is_low(fmt_new)) begin
               lj_sh  <= '0;
               lj_cnt <= '0;
            end else begin
               lj_sh  <= {{(W-1){1'b0}}, dat_bit};
               lj_cnt <= CW'(1);
            end
         end else if (lj_cnt < CW'(W)) begin
            lj_sh  <= {lj_sh[W-2:0], dat_bit};
            lj_cnt <= lj_cnt + 1'b1;
         end
      end
   end

   // R2: the leading-edge capture never runs past one word.
   p_lj_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lj_cnt <= CW'(W));

   // R9: without a bit-clock rise the capture state stays put.
   p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> ($stable(lr_prev) && $stable(rj_sh) && $stable(lj_sh)));

endmodule

// File: rtl/ser_audio_rx_pair.sv
module ser_audio_rx_pair #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         half_done,
   input  logic         half_left,
   input  logic [W-1:0] half_word,
   output logic [W-1:0] left_o,
   output logic [W-1:0] right_o,
   output logic         valid_o
);

   logic [W-1:0] left_hold;
   logic         have_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold <= '0;
         have_left <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (half_done) begin
            if (half_left) begin
               left_hold <= half_word;
               have_left <= 1'b1;
            end else if (have_left) begin
               left_o    <= left_hold;
               right_o   <= half_word;
               valid_o   <= 1'b1;
               have_left <= 1'b0;
            end
         end
      end
   end

   // R8: a pair strobe lasts exactly one cycle.
   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: a pair is only issued once a left half was held.
   p_pair_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($past(have_left) && !have_left));

   // R9: outputs move only together with the strobe.
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int SAMPLE_W    = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                lrck_i,
   input  logic                sdata_i,
   input  logic [2:0]          fmt_sel_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   generate
      if (SAMPLE_W < 24 || SAMPLE_W > 64) begin : g_bad_width
         $error("ser_audio_rx: SAMPLE_W must lie in 24..64");
      end
   endgenerate

   logic                bit_stb;
   logic                lr_bit;
   logic                dat_bit;
   logic                half_done;
   logic                half_left;
   logic [SAMPLE_W-1:0] half_word;

   ser_audio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .lrck_i  (lrck_i),
      .sdata_i (sdata_i),
      .bit_stb (bit_stb),
      .lr_bit  (lr_bit),
      .dat_bit (dat_bit)
   );

   ser_audio_rx_deser #(.W(SAMPLE_W)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .lr_bit    (lr_bit),
      .dat_bit   (dat_bit),
      .fmt_code  (fmt_sel_i),
      .half_done (half_done),
      .half_left (half_left),
      .half_word (half_word)
   );

   ser_audio_rx_pair #(.W(SAMPLE_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_done (half_done),
      .half_left (half_left),
      .half_word (half_word),
      .left_o    (left_o),
      .right_o   (right_o),
      .valid_o   (valid_o)
   );

endmodule

// File: tb/ser_audio_rx_bench.sv
module ser_audio_rx_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int W          = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk = 1'b0;
   logic         lrck = 1'b0;
   logic         sdata = 1'b0;
   logic [2:0]   fmt = 3'd2;
   logic [W-1:0] left_o, right_o;
   logic         valid_o;

   ser_audio_rx #(.SYNC_STAGES(SYNC), .SAMPLE_W(W)) u_ser_audio_rx (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
      .fmt_sel_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // Behavioural timing model fed by bit events
   int           due_q[$];
   logic [2*W-1:0] exp_q[$];
   string        tag_q[$];
   bit m_prev_lr = 0, m_armed = 0, m_i2s = 0, m_have_left = 0;
   bit carry = 1'b1;
   logic [W-1:0] last_l = '0, last_r = '0;

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic model_step(input bit lr);
      if (lr != m_prev_lr) begin
         if (m_armed) begin
            if (m_prev_lr != m_i2s) m_have_left = 1;
            else if (m_have_left) begin
               due_q.push_back(cyc + 1 + SYNC);
               m_have_left = 0;
            end
         end
         m_armed = 1;
         m_i2s = (fmt == 3'd3);
      end
      m_prev_lr = lr;
   endtask

   task automatic bit_out(input bit lr, input bit d);
      @(negedge clk); bclk = 1'b0; lrck = lr; sdata = d;
      @(negedge clk);
      @(negedge clk); bclk = 1'b1; model_step(lr);
      @(negedge clk);
   endtask

   task automatic send_half(input int f, input int h, input logic [W-1:0] s, input bit lvl);
      for (int p = 0; p < h; p++) begin
         bit b = 1'b1;
         case (f)
            0: if (p >= h-16) b = s[W-1-(p-(h-16))];
            1: if (p >= h-20) b = s[W-1-(p-(h-20))];
            4: if (p >= h-24) b = s[W-1-(p-(h-24))];
            3: if (p == 0) b = carry; else if (p-1 < W) b = s[W-p];
            default: if (p < W) b = s[W-1-p];
         endcase
         bit_out(lvl, b);
      end
      carry = (f == 3 && h == W) ? s[0] : 1'b1;
   endtask

   task automatic send_frame(input logic [2:0] f, input int h, input string tag);
      logic [W-1:0] sl, sr, ml;
      bit lft;
      sl = W'($urandom);
      sr = W'($urandom);
      ml = (f == 3'd0) ? ('1 << 8) : (f == 3'd1) ? ('1 << 4) : '1;
      fmt = f;
      lft = (f != 3'd3);
      send_half(int'(f), h, sl, lft);
      send_half(int'(f), h, sr, !lft);
      exp_q.push_back({sl & ml, sr & ml});
      tag_q.push_back(tag);
   endtask

   // Short filler half: first bit carries a pending I2S LSB
   task automatic sep(input logic [2:0] f, input bit lvl);
      fmt = f;
      bit_out(lvl, carry);
      carry = 1'b1;
      for (int i = 0; i < 5; i++) bit_out(lvl, 1'b1);
   endtask

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_v;
         exp_v = (due_q.size() > 0 && due_q[0] == cyc);
         if (exp_v) void'(due_q.pop_front());
         n_chk++;
         if (valid_o !== exp_v) begin
            n_bad++;
            $display("FAIL R8 valid timing at cycle %0d: actual=%b expected=%b", cyc, valid_o, exp_v);
         end
         if (valid_o === 1'b1 && exp_v) begin
            logic [2*W-1:0] e;
            string t;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            t = (tag_q.size() > 0) ? tag_q.pop_front() : "R8";
            n_chk++;
            if (left_o !== e[2*W-1:W] || right_o !== e[W-1:0]) begin
               n_bad++;
               $display("FAIL %s pair: actual L=%h R=%h expected L=%h R=%h",
                        t, left_o, right_o, e[2*W-1:W], e[W-1:0]);
            end
            last_l = left_o;
            last_r = right_o;
         end else if (valid_o !== 1'b1) begin
            n_chk++;
            if (left_o !== last_l || right_o !== last_r) begin
               n_bad++;
               $display("FAIL R9 hold: actual L=%h R=%h expected L=%h R=%h",
                        left_o, right_o, last_l, last_r);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: actual v=%b L=%h R=%h expected v=0 L=0 R=0", valid_o, left_o, right_o);
      end
      rst_n = 1'b1;
      // R10: bits before any frame-clock transition give nothing
      fmt = 3'd2;
      for (int i = 0; i < 30; i++) bit_out(1'b0, 1'(i % 3));
      // R2 and R11: left-justified, long and minimum halves
      send_frame(3'd2, 32, "R2");
      send_frame(3'd2, 32, "R2");
      send_frame(3'd2, 24, "R2");
      // R7: spare codes act as code 2
      send_frame(3'd6, 32, "R7");
      send_frame(3'd7, 24, "R7");
      send_frame(3'd5, 32, "R7");
      // R4: 24-bit right-justified
      send_frame(3'd4, 32, "R4");
      send_frame(3'd4, 24, "R4");
      // R5: 16-bit right-justified
      send_frame(3'd0, 16, "R5");
      send_frame(3'd0, 32, "R5");
      // R6: 20-bit right-justified
      send_frame(3'd1, 20, "R6");
      send_frame(3'd1, 32, "R6");
      // R3: I2S after a polarity separator
      sep(3'd3, 1'b1);
      send_frame(3'd3, 24, "R3");
      send_frame(3'd3, 24, "R3");
      send_frame(3'd3, 32, "R3");
      // R9 and R11: back to high-left framing
      sep(3'd2, 1'b0);
      send_frame(3'd2, 32, "R9");
      sep(3'd2, 1'b1);
      repeat (20) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0 || due_q.size() != 0) begin
         n_bad++;
         $display("FAIL R8 pending pairs: actual=%0d expected=0", exp_q.size() + due_q.size());
      end
      finish_run();
   end

endmodule